// File: doc/BRIEF.md
# Fixed-Head Disk Controller Register Front End

This block is the programmer-visible side of a word-addressed fixed-head disk controller sitting on a 16-bit memory-mapped bus. It decodes eight word registers from bus address bits 3:1 and accepts both full-word and byte writes. It keeps the control/status word, the word count, the current memory address, the disk address with its high extension, a data buffer word and a maintenance word. The eighth register is a read-only window onto the rotational position that the transfer engine supplies.

The block hands the transfer engine a one-cycle start strobe with the selected function. It also gives the engine the full disk address, the full memory address, the word count and the address-inhibit flag. In return it takes a done pulse and error pulses from the engine. It folds the individual error flags into a freeze bit and an error summary bit. It flags a disk address beyond the configured capacity at all times. It drives a level interrupt request to the processor. Writing the clear bit returns the controller to its idle state and emits an abort pulse that cancels any transfer in progress.

Top module: `dskc_regs`

## Requirements
- R1: Register select is `bus_addr_i[3:1]`: 0 control/status, 1 word count, 2 memory address, 3 disk address, 4 disk address extension, 5 data buffer, 6 maintenance, 7 position. Register 7 reads `pos_i`, and writes to it change nothing.
- R2: With `bus_byte_i`=1, a write with `bus_addr_i[0]`=1 replaces bits 15:8 from `bus_wdata_i[15:8]`, and a write with `bus_addr_i[0]`=0 replaces bits 7:0 from `bus_wdata_i[7:0]`. The other byte keeps its read value. With `bus_byte_i`=0 the whole word is replaced.
- R3: Control/status layout: bit 0 go, bits 2:1 function (0 none, 1 write, 2 read, 3 write-check), bit 3 maintenance, bits 5:4 memory extension, bit 6 interrupt enable, bit 7 done, bit 8 clear, bit 9 missed transfer, bit 10 write lock, bit 11 nonexistent disk, bit 12 parity, bit 13 write-check error, bit 14 freeze, bit 15 error. Only bits 6, 5:4 and 2:1 take written values. Bits 0, 3 and 8 read 0.
- R4: A write to control/status starts a command when done was 1, bit 0 is written 1 and the written function is not 0. On the next cycle `start_o` is 1 for one cycle and `fn_o` holds the function. Done, bits 13, 12, 10 and 9 and the interrupt request are cleared. In every other case no start occurs and done is unchanged.
- R5: `eng_done_i` sets done. `eng_wchk_i`, `eng_par_i`, `eng_wlk_i` and `eng_miss_i` set status bits 13, 12, 10 and 9. `eng_ext_err_i[i]` sets extension bit 10+i, where bit 10 means nonexistent memory. `eng_late_i` sets extension bit 7.
- R6: Status bit 14 reads 1 exactly when any extension bit 15:10 is 1. Status bit 15 reads 1 exactly when any status bit 14:9 is 1. Extension error bits survive a command start.
- R7: Status bit 11 reads 1 exactly when {extension[5:0], disk address} is at or above CAPACITY (default 2097152 words). It is recomputed whenever either register changes.
- R8: `irq_o` rises when done goes 0 to 1 while enable is 1. It also rises when enable is written 1 while done is 1. Writing enable 0 drops it at once. Otherwise it holds until a command start or a clear.
- R9: Writing control/status with bit 8 = 1 clears the controller. Control/status then reads 0x0080, registers 1 to 6 read 0, `irq_o` is 0, `abort_o` pulses for one cycle and no start occurs.
- R10: The memory address register always reads bit 0 as 0, whatever was written.
- R11: The extension register reads only bits 15:10, 8, 7 and 5:0. A write changes only bits 8, 7 and 5:0.
- R12: After reset, control/status reads 0x0080, registers 1 to 6 read 0 and `irq_o`, `start_o` and `abort_o` are 0.
- R13: `disk_addr_o` = {extension[5:0], disk address}, `mem_addr_o` = {status[5:4], memory address}, `wc_o` = word count and `inhibit_o` = extension bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_byte_i | input | 1 | Byte write when 1 |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 16 | Write data, byte-lane aligned |
| bus_rdata_o | output | 16 | Read data of the selected register |
| pos_i | input | 16 | Rotational position from the engine |
| eng_done_i | input | 1 | Transfer finished pulse |
| eng_wchk_i | input | 1 | Write-check miscompare pulse |
| eng_par_i | input | 1 | Data parity error pulse |
| eng_wlk_i | input | 1 | Write-locked track pulse |
| eng_miss_i | input | 1 | Missed transfer pulse |
| eng_ext_err_i | input | 6 | Extension error pulses for bits 15:10 |
| eng_late_i | input | 1 | Request-late pulse |
| start_o | output | 1 | One-cycle command start strobe |
| fn_o | output | 2 | Current function code |
| abort_o | output | 1 | One-cycle cancel strobe on clear |
| irq_o | output | 1 | Interrupt request level |
| disk_addr_o | output | 22 | Full disk word address |
| mem_addr_o | output | 18 | Full memory byte address |
| wc_o | output | 16 | Word count |
| inhibit_o | output | 1 | Memory address inhibit |

## Verification
The interrupt paths are the hardest to reach. The request can rise from a done edge or from enable being written while done is already set. It can also fall because of a start, a disabling write or a clear. Each of these depends on done being low, which only a real command start produces. The random mix therefore weights control/status writes toward a set go bit with a nonzero function, and interleaves engine done pulses, so that every mix of enable and done occurs many times. Directed steps also place the disk address on both sides of the capacity boundary. They also show that extension errors keep freeze set across a start.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    localparam int WORD_W      = 16;
    localparam int EXT_HI_W    = 6;
    localparam int DISK_ADDR_W = WORD_W + EXT_HI_W;
    localparam int MEX_W       = 2;
    localparam int MEM_ADDR_W  = WORD_W + MEX_W;
    localparam int EXT_ERR_LSB = 10;

    localparam logic [WORD_W-1:0] EXT_RD_MASK = 16'o176677;
    localparam logic [WORD_W-1:0] EXT_WR_MASK = 16'o000677;

    typedef enum logic [2:0] {
        SEL_CSR  = 3'd0,
        SEL_CNT  = 3'd1,
        SEL_MADR = 3'd2,
        SEL_DADR = 3'd3,
        SEL_DEXT = 3'd4,
        SEL_DBUF = 3'd5,
        SEL_MNT  = 3'd6,
        SEL_POS  = 3'd7
    } sel_e;

    typedef enum logic [1:0] {
        FN_IDLE  = 2'd0,
        FN_WRITE = 2'd1,
        FN_READ  = 2'd2,
        FN_CHECK = 2'd3
    } fn_e;

    typedef struct packed {
        logic              ie;
        logic [MEX_W-1:0]  mex;
        fn_e               fn;
        logic              done;
        logic              f_wchk;
        logic              f_par;
        logic              f_wlk;
        logic              f_miss;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-2:0] madr;
        logic [WORD_W-1:0] dadr;
        logic [WORD_W-1:0] dext;
        logic [WORD_W-1:0] dbuf;
        logic [WORD_W-1:0] mnt;
        logic              irq;
        logic              start;
        logic              abort;
    } regs_t;

endpackage

// File: rtl/dskc_lane_merge.sv
module dskc_lane_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] new_i,
    input  logic         byte_i,
    input  logic         odd_i,
    output logic [W-1:0] merged_o
);
    localparam int LANES = W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic take;
        assign take = !byte_i || (odd_i == g[0]);
        assign merged_o[g*8 +: 8] = take ? new_i[g*8 +: 8] : old_i[g*8 +: 8];
    end
endmodule

// File: rtl/dskc_status_sum.sv
module dskc_status_sum #(
    parameter int          ADDR_W   = 22,
    parameter int unsigned CAPACITY = 2097152
) (
    input  logic [ADDR_W-1:0] disk_addr_i,
    input  logic [5:0]        ext_err_i,
    input  logic [3:0]        flags_i,
    output logic              ned_o,
    output logic              frz_o,
    output logic              err_o
);
    localparam int CMP_W = ADDR_W + 1;
    localparam logic [CMP_W-1:0] CAP_V = CMP_W'(CAPACITY);

    always_comb begin
        ned_o = ({1'b0, disk_addr_i} >= CAP_V);
        frz_o = |ext_err_i;
        err_o = frz_o | ned_o | (|flags_i);
    end
endmodule

// File: rtl/dskc_regs.sv
module dskc_regs
    import dskc_pkg::*;
#(
    parameter int unsigned CAPACITY = 2097152
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_i,
    input  logic                   bus_byte_i,
    input  logic [3:0]             bus_addr_i,
    input  logic [WORD_W-1:0]      bus_wdata_i,
    output logic [WORD_W-1:0]      bus_rdata_o,
    input  logic [WORD_W-1:0]      pos_i,
    input  logic                   eng_done_i,
    input  logic                   eng_wchk_i,
    input  logic                   eng_par_i,
    input  logic                   eng_wlk_i,
    input  logic                   eng_miss_i,
    input  logic [EXT_HI_W-1:0]    eng_ext_err_i,
    input  logic                   eng_late_i,
    output logic                   start_o,
    output logic [1:0]             fn_o,
    output logic                   abort_o,
    output logic                   irq_o,
    output logic [DISK_ADDR_W-1:0] disk_addr_o,
    output logic [MEM_ADDR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0]      wc_o,
    output logic                   inhibit_o
);
    regs_t q, n;

    sel_e              sel;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] csr_rd;
    logic              ned_w, frz_w, err_w;
    logic              clr_hit;

    assign sel = sel_e'(bus_addr_i[3:1]);

    dskc_status_sum #(
        .ADDR_W   (DISK_ADDR_W),
        .CAPACITY (CAPACITY)
    ) sum_i (
        .disk_addr_i (disk_addr_o),
        .ext_err_i   (q.dext[WORD_W-1:EXT_ERR_LSB]),
        .flags_i     ({q.f_wchk, q.f_par, q.f_wlk, q.f_miss}),
        .ned_o       (ned_w),
        .frz_o       (frz_w),
        .err_o       (err_w)
    );

    assign csr_rd = {err_w, frz_w, q.f_wchk, q.f_par, ned_w, q.f_wlk, q.f_miss,
                     1'b0, q.done, q.ie, q.mex, 1'b0, q.fn, 1'b0};

    always_comb begin
        unique case (sel)
            SEL_CSR:  bus_rdata_o = csr_rd;
            SEL_CNT:  bus_rdata_o = q.cnt;
            SEL_MADR: bus_rdata_o = {q.madr, 1'b0};
            SEL_DADR: bus_rdata_o = q.dadr;
            SEL_DEXT: bus_rdata_o = q.dext & EXT_RD_MASK;
            SEL_DBUF: bus_rdata_o = q.dbuf;
            SEL_MNT:  bus_rdata_o = q.mnt;
            default:  bus_rdata_o = pos_i;
        endcase
    end

    dskc_lane_merge #(.W(WORD_W)) merge_i (
        .old_i    (bus_rdata_o),
        .new_i    (bus_wdata_i),
        .byte_i   (bus_byte_i),
        .odd_i    (bus_addr_i[0]),
        .merged_o (merged)
    );

    assign clr_hit = bus_wr_i && (sel == SEL_CSR) && merged[8];

    always_comb begin
        n       = q;
        n.start = 1'b0;
        n.abort = 1'b0;
        if (bus_wr_i) begin
            unique case (sel)
                SEL_CSR: begin
                    if (merged[8]) begin
                        n       = '0;
                        n.done  = 1'b1;
                        n.abort = 1'b1;
                    end else begin
                        n.ie  = merged[6];
                        n.mex = merged[5:4];
                        n.fn  = fn_e'(merged[2:1]);
                        if (!merged[6]) begin
                            n.irq = 1'b0;
                        end else if (q.done) begin
                            n.irq = 1'b1;
                        end
                        if (q.done && merged[0] && (merged[2:1] != FN_IDLE)) begin
                            n.start  = 1'b1;
                            n.done   = 1'b0;
                            n.f_wchk = 1'b0;
                            n.f_par  = 1'b0;
                            n.f_wlk  = 1'b0;
                            n.f_miss = 1'b0;
                            n.irq    = 1'b0;
                        end
                    end
                end
                SEL_CNT:  n.cnt  = merged;
                SEL_MADR: n.madr = merged[WORD_W-1:1];
                SEL_DADR: n.dadr = merged;
                SEL_DEXT: n.dext = (q.dext & ~EXT_WR_MASK) | (merged & EXT_WR_MASK);
                SEL_DBUF: n.dbuf = merged;
                SEL_MNT:  n.mnt  = merged;
                default:  ;
            endcase
        end
        if (!n.abort) begin
            if (eng_done_i && !n.done && n.ie) begin
                n.irq = 1'b1;
            end
            n.done   = n.done   | eng_done_i;
            n.f_wchk = n.f_wchk | eng_wchk_i;
            n.f_par  = n.f_par  | eng_par_i;
            n.f_wlk  = n.f_wlk  | eng_wlk_i;
            n.f_miss = n.f_miss | eng_miss_i;
            n.dext[WORD_W-1:EXT_ERR_LSB] = n.dext[WORD_W-1:EXT_ERR_LSB] | eng_ext_err_i;
            n.dext[7] = n.dext[7] | eng_late_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign start_o     = q.start;
    assign abort_o     = q.abort;
    assign fn_o        = q.fn;
    assign irq_o       = q.irq;
    assign disk_addr_o = {q.dext[EXT_HI_W-1:0], q.dadr};
    assign mem_addr_o  = {q.mex, q.madr, 1'b0};
    assign wc_o        = q.cnt;
    assign inhibit_o   = q.dext[8];

    // R4: a start leaves the controller busy with a real function
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!q.done && (fn_o != FN_IDLE)));

    // R4: a start withdraws the interrupt request
    a_r4_start_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !irq_o);

    // R8: the request never stands without enable
    a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> q.ie);

    // R8: the request only rises while done is set
    a_r8_irq_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> q.done);

    // R9: a clear leaves the idle register image
    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (q.done && !irq_o && !start_o && wc_o == '0 && disk_addr_o == '0));

    // R5: an engine done pulse is always recorded unless a clear wins
    a_r5_done_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done_i && !clr_hit) |=> q.done);

endmodule

// File: tb/dskc_regs_tb_top.sv
`timescale 1ns/1ps
module dskc_regs_tb_top;

    localparam int unsigned CAP = 2097152;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0, bus_byte_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [15:0] pos_i = 16'h0000;
    logic        eng_done_i = 0, eng_wchk_i = 0, eng_par_i = 0, eng_wlk_i = 0, eng_miss_i = 0;
    logic [5:0]  eng_ext_err_i = '0;
    logic        eng_late_i = 0;
    logic        start_o, abort_o, irq_o, inhibit_o;
    logic [1:0]  fn_o;
    logic [21:0] disk_addr_o;
    logic [17:0] mem_addr_o;
    logic [15:0] wc_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dskc_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_byte_i(bus_byte_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .pos_i(pos_i), .eng_done_i(eng_done_i), .eng_wchk_i(eng_wchk_i),
        .eng_par_i(eng_par_i), .eng_wlk_i(eng_wlk_i), .eng_miss_i(eng_miss_i),
        .eng_ext_err_i(eng_ext_err_i), .eng_late_i(eng_late_i),
        .start_o(start_o), .fn_o(fn_o), .abort_o(abort_o), .irq_o(irq_o),
        .disk_addr_o(disk_addr_o), .mem_addr_o(mem_addr_o), .wc_o(wc_o),
        .inhibit_o(inhibit_o)
    );

    // reference state built from the requirements
    logic        m_ie, m_done, m_wchk, m_par, m_wlk, m_miss, m_irq;
    logic [1:0]  m_mex, m_fn;
    logic [15:0] m_cnt, m_ma, m_da, m_dext, m_dbuf, m_mnt;
    logic        x_start, x_abort;

    task automatic m_reset(input logic ab);
        m_ie = 0; m_done = 1; m_wchk = 0; m_par = 0; m_wlk = 0; m_miss = 0; m_irq = 0;
        m_mex = 0; m_fn = 0; m_cnt = 0; m_ma = 0; m_da = 0; m_dext = 0; m_dbuf = 0; m_mnt = 0;
        x_start = 0; x_abort = ab;
    endtask

    function automatic logic [15:0] m_csr();
        logic ned, frz, err;
        ned = ({1'b0, m_dext[5:0], m_da} >= 23'(CAP));
        frz = |m_dext[15:10];
        err = frz | ned | m_wchk | m_par | m_wlk | m_miss;
        return {err, frz, m_wchk, m_par, ned, m_wlk, m_miss, 1'b0, m_done, m_ie, m_mex, 1'b0, m_fn, 1'b0};
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] s);
        case (s)
            3'd0: return m_csr();
            3'd1: return m_cnt;
            3'd2: return m_ma;
            3'd3: return m_da;
            3'd4: return m_dext & 16'o176677;
            3'd5: return m_dbuf;
            3'd6: return m_mnt;
            default: return pos_i;
        endcase
    endfunction

    task automatic m_write(input logic [2:0] s, input logic byt, input logic odd, input logic [15:0] d);
        logic [15:0] old, mg;
        old = m_read(s);
        mg = d;
        if (byt) mg = odd ? {d[15:8], old[7:0]} : {old[15:8], d[7:0]};
        x_start = 0; x_abort = 0;
        case (s)
            3'd0: begin
                if (mg[8]) m_reset(1'b1);
                else begin
                    m_ie = mg[6]; m_mex = mg[5:4]; m_fn = mg[2:1];
                    if (!mg[6]) m_irq = 0; else if (m_done) m_irq = 1;
                    if (m_done && mg[0] && mg[2:1] != 2'd0) begin
                        x_start = 1; m_done = 0; m_wchk = 0; m_par = 0; m_wlk = 0; m_miss = 0; m_irq = 0;
                    end
                end
            end
            3'd1: m_cnt = mg;
            3'd2: m_ma = {mg[15:1], 1'b0};
            3'd3: m_da = mg;
            3'd4: m_dext = (m_dext & ~16'o000677) | (mg & 16'o000677);
            3'd5: m_dbuf = mg;
            3'd6: m_mnt = mg;
            default: ;
        endcase
    endtask

    task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pulses();
        chk(start_o, x_start, "R4 start_o");
        chk(abort_o, x_abort, "R9 abort_o");
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic byt);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_byte_i = byt; bus_wr_i = 1;
        @(posedge clk);
        #1;
        bus_wr_i = 0; bus_byte_i = 0;
        m_write(a[3:1], byt, a[0], d);
        chk_pulses();
    endtask

    task automatic eng(input logic dn, input logic [3:0] fl, input logic [5:0] ext, input logic late);
        @(negedge clk);
        eng_done_i = dn; {eng_wchk_i, eng_par_i, eng_wlk_i, eng_miss_i} = fl;
        eng_ext_err_i = ext; eng_late_i = late;
        @(posedge clk);
        #1;
        eng_done_i = 0; {eng_wchk_i, eng_par_i, eng_wlk_i, eng_miss_i} = 4'b0;
        eng_ext_err_i = 0; eng_late_i = 0;
        x_start = 0; x_abort = 0;
        if (dn && !m_done && m_ie) m_irq = 1;
        if (dn) m_done = 1;
        m_wchk |= fl[3]; m_par |= fl[2]; m_wlk |= fl[1]; m_miss |= fl[0];
        m_dext[15:10] |= ext;
        if (late) m_dext[7] = 1;
        chk_pulses();
    endtask

    task automatic chk_all(input string tag);
        @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            bus_addr_i = 4'(s * 2);
            #0.2;
            chk(bus_rdata_o, m_read(3'(s)), $sformatf("%s R1 reg%0d", tag, s));
        end
        chk(irq_o, m_irq, {tag, " R8 irq"});
        chk(fn_o, m_fn, {tag, " R13 fn"});
        chk(disk_addr_o, {m_dext[5:0], m_da}, {tag, " R13 disk_addr"});
        chk(mem_addr_o, {m_mex, m_ma}, {tag, " R13 mem_addr"});
        chk(wc_o, m_cnt, {tag, " R13 wc"});
        chk(inhibit_o, m_dext[8], {tag, " R13 inhibit"});
    endtask

    task automatic chk_csr(input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr_i = 4'd0;
        #0.2;
        chk(bus_rdata_o, exp, tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        m_reset(1'b0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk_csr(16'h0080, "R12 reset csr");
        chk(irq_o, 0, "R12 reset irq");
        chk(start_o, 0, "R12 reset start");
        chk_all("R12");

        // R2 byte lanes
        bus_wr(4'd6, 16'h1234, 0);
        bus_wr(4'd7, 16'hAB00, 1);
        bus_wr(4'd6, 16'h00CD, 1);
        chk(m_da, 16'hABCD, "R2 model");
        chk_all("R2");
        // R1 position is read-only
        pos_i = 16'h5A5A;
        bus_wr(4'd14, 16'hFFFF, 0);
        chk_all("R1 pos");
        // R10
        bus_wr(4'd4, 16'hFFFF, 0);
        chk_all("R10");
        // R11 masks
        bus_wr(4'd8, 16'hFFFF, 0);
        chk_all("R11");
        // R7 boundary
        bus_wr(4'd8, 16'h001F, 0);
        bus_wr(4'd6, 16'hFFFF, 0);
        chk_csr(16'h0080, "R7 below capacity");
        bus_wr(4'd8, 16'h0020, 0);
        bus_wr(4'd6, 16'h0000, 0);
        chk_csr(16'h8880, "R7 at capacity");
        bus_wr(4'd8, 16'h0000, 0);
        chk_csr(16'h0080, "R7 cleared");
        // R8 enable while done
        bus_wr(4'd0, 16'h0040, 0);
        chk(irq_o, 1, "R8 enable while done");
        bus_wr(4'd0, 16'h0000, 0);
        chk(irq_o, 0, "R8 disable drops");
        // R3 writability
        bus_wr(4'd0, 16'hFEF8, 0);
        chk_csr(16'h0070 | 16'h0080, "R3 writable bits");
        // R4 start
        bus_wr(4'd0, 16'h0045, 0);
        chk(start_o, 1, "R4 start pulse");
        chk(fn_o, 2, "R4 function");
        chk_csr(16'h0044, "R4 done cleared");
        bus_wr(4'd0, 16'h0043, 0);
        chk(start_o, 0, "R4 no start while busy");
        eng(1, 4'b1000, 6'b000000, 0);
        chk(irq_o, 1, "R8 done edge");
        chk_csr(16'hA0C2, "R5 wchk flag");
        bus_wr(4'd0, 16'h0041, 0);
        chk(start_o, 0, "R4 no-op function");
        chk(irq_o, 1, "R8 held");
        // R6 freeze survives start
        eng(0, 4'b0000, 6'b000001, 1);
        bus_wr(4'd0, 16'h0043, 0);
        chk(start_o, 1, "R4 second start");
        chk_csr(16'hC042, "R6 freeze kept");
        chk_all("R6");
        // R9 clear
        bus_wr(4'd2, 16'h1111, 0);
        bus_wr(4'd1, 16'h0100, 1);
        chk(abort_o, 1, "R9 abort");
        chk_all("R9");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom % 10;
            if (op < 4) begin
                logic [15:0] d;
                d = 16'($urandom);
                if (($urandom % 8) != 0) d[8] = 0;
                if (($urandom % 2) == 0) d[0] = 1;
                bus_wr({3'd0, 1'($urandom % 2)}, d, 1'($urandom % 3 == 0));
            end else if (op < 7) begin
                eng(1'($urandom % 2), 4'($urandom % 16 & $urandom % 16 & $urandom % 16),
                    6'($urandom & $urandom & $urandom & $urandom), 1'($urandom % 8 == 0));
            end else begin
                pos_i = 16'($urandom);
                bus_wr(4'($urandom % 16), 16'($urandom), 1'($urandom % 2));
            end
            chk_all("rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule